// File: doc/BRIEF.md
# Receive Destination Address Filter

This block sits at the head of a receive path and decides, for each incoming frame, whether the frame is kept or dropped. It looks only at the 48-bit destination address. The address arrives as the first six bytes of the frame, one byte per strobe, first byte first. While those bytes arrive, the block compares the address with two programmable station addresses and with the all-ones broadcast address. In the same pass it folds the address into a 6-bit hash. That hash indexes a 64-bit group table.

A frame is accepted when any enabled comparison hits or when the hash selects a set table bit. The hash lookup covers group addresses only, unless a control bit extends it to individual addresses. The verdict is given one cycle after the twelfth byte, as a one-cycle strobe with an accept flag. A frame that ends before twelve bytes is rejected, and its verdict is given one cycle after its end marker. Control and table inputs are expected to stay steady while a frame's address bytes are being taken in.

Top module: `dafilt_top`

## Requirements
- R1: With `rx_ctl[0]` set, a frame whose six address bytes equal station address 0 is accepted. With that bit clear, station address 0 has no effect on the verdict.
- R2: Station address `k` is held as `ucK_lo` and `ucK_hi`. Address byte 0 is in `ucK_lo[7:0]`, byte 1 in `ucK_lo[15:8]`, byte 2 in `ucK_lo[23:16]`, byte 3 in `ucK_lo[31:24]`, byte 4 in `ucK_hi[7:0]` and byte 5 in `ucK_hi[15:8]`. With `rx_ctl[1]` set, a frame matching station address 1 on all six bytes is accepted, and a mismatch in any single byte does not count as a match.
- R3: With `rx_ctl[3]` set, a frame whose address is all ones is accepted. With it clear, the all-ones address earns no acceptance of its own.
- R4: Let bit `8*i+j` of a 48-bit vector A be bit j of address byte i. The hash is the XOR of the eight fields A[6k+5:6k], for k = 0 to 7. Hash values 0 to 31 select bit `hash` of `grp_tbl_lo`, and values 32 to 63 select bit `hash-32` of `grp_tbl_hi`. A selected bit of 1 is a hash hit.
- R5: A hash hit counts only when bit 0 of address byte 0 is 1 (a group address) or when `rx_ctl[2]` is set.
- R6: The accept flag is the OR of the enabled exact hits, the enabled broadcast hit and the qualified hash hit. In every other case the frame is rejected.
- R7: The verdict strobe `dec_vld` is high for exactly one cycle, the cycle after the twelfth byte of the frame is taken. A frame gets exactly one verdict, however long it is.
- R8: If `eof` arrives while fewer than twelve bytes of the frame have been taken, the frame is rejected, with `dec_vld` high one cycle after `eof`. This holds even if its address would match. When `eof` comes with the twelfth byte, a single verdict based on the address is given.
- R9: `sof` marks the first byte of a frame and abandons any frame in progress. An `eof` or extra bytes after the verdict give no further strobe.
- R10: `dec_accept` is low whenever `dec_vld` is low, including after reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| rx_ctl | input | 4 | Filter control: [0] station 0 enable, [1] station 1 enable, [2] hash individual addresses too, [3] broadcast enable |
| uc0_lo | input | 32 | Station address 0, bytes 0 to 3 |
| uc0_hi | input | 16 | Station address 0, bytes 4 and 5 |
| uc1_lo | input | 32 | Station address 1, bytes 0 to 3 |
| uc1_hi | input | 16 | Station address 1, bytes 4 and 5 |
| grp_tbl_lo | input | 32 | Group table, entries 0 to 31 |
| grp_tbl_hi | input | 32 | Group table, entries 32 to 63 |
| sof | input | 1 | First byte of frame, qualified by byte_vld |
| byte_vld | input | 1 | Byte strobe |
| byte_dat | input | 8 | Frame byte |
| eof | input | 1 | End of frame; may coincide with a byte |
| dec_vld | output | 1 | Verdict strobe |
| dec_accept | output | 1 | Verdict: 1 keep, 0 drop |

## Verification
Two verdict sources can fall in the same cycle: the length rule, which fires on the twelfth byte, and the end marker, which rejects short frames. The bench sends twelve-byte frames with `eof` on the last byte. It checks for exactly one strobe, carrying the address-based verdict rather than a reject. It also sends `eof` together with the first byte, and after a verdict has already been given, to show that the two sources never double up. A full sweep of all 64 hash values against single-bit tables covers R4 and R5. Seeded random frames are then checked against an arithmetic model of the filter.

// File: rtl/dafilt_pkg.sv
package dafilt_pkg;
   localparam int unsigned ADDR_BYTES = 6;
   localparam int unsigned HASH_W     = 6;
   localparam int unsigned TBL_SIZE   = 1 << HASH_W;
   localparam int unsigned BIDX_W     = $clog2(ADDR_BYTES);

   // Byte b placed at bit offset 8*pos of the address, folded onto HASH_W bits
   function automatic logic [HASH_W-1:0] fold_byte(input logic [7:0] b, input int unsigned pos);
      logic [HASH_W-1:0] r;
      int unsigned base;
      r    = '0;
      base = (pos * 8) % HASH_W;
      for (int unsigned j = 0; j < 8; j++) begin
         r[(base + j) % HASH_W] = r[(base + j) % HASH_W] ^ b[j];
      end
      return r;
   endfunction
endpackage

// File: rtl/dafilt_exact.sv
module dafilt_exact
   import dafilt_pkg::*;
#(
   parameter int unsigned BYTES = ADDR_BYTES
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 upd,
   input  logic                 first,
   input  logic [BIDX_W-1:0]    idx,
   input  logic [7:0]           dat,
   input  logic [BYTES*8-1:0]   ref_addr,
   output logic                 eq
);
   logic eq_q;
   logic byte_hit;

   assign byte_hit = (dat == ref_addr[idx*8 +: 8]);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         eq_q <= 1'b0;
      end else if (upd) begin
         eq_q <= byte_hit & (first | eq_q);
      end
   end

   assign eq = eq_q;

   // A mismatching byte clears the running compare for the rest of the address
   AST_MISS_STICKS: assert property (@(posedge clk) disable iff (!rst_n)
      (upd && !first && !byte_hit) |=> !eq_q); // R2
endmodule

// File: rtl/dafilt_hash.sv
module dafilt_hash
   import dafilt_pkg::*;
(
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 upd,
   input  logic                 first,
   input  logic [BIDX_W-1:0]    idx,
   input  logic [7:0]           dat,
   output logic [HASH_W-1:0]    hash,
   output logic                 grp
);
   logic [HASH_W-1:0] acc_q;
   logic              grp_q;
   logic [HASH_W-1:0] part;

   assign part = fold_byte(dat, int'(idx));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         acc_q <= '0;
         grp_q <= 1'b0;
      end else if (upd) begin
         acc_q <= first ? part : (acc_q ^ part);
         if (first) grp_q <= dat[0];
      end
   end

   assign hash = acc_q;
   assign grp  = grp_q;

   AST_HASH_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      !upd |=> $stable(acc_q)); // R4
endmodule

// File: rtl/dafilt_top.sv
module dafilt_top
   import dafilt_pkg::*;
#(
   parameter int unsigned MIN_FRAME  = 12,
   parameter bit          MATCH_PIPE = 1'b1
) (
   input  logic        clk,
   input  logic        rst_n,
   input  logic [3:0]  rx_ctl,
   input  logic [31:0] uc0_lo,
   input  logic [15:0] uc0_hi,
   input  logic [31:0] uc1_lo,
   input  logic [15:0] uc1_hi,
   input  logic [31:0] grp_tbl_lo,
   input  logic [31:0] grp_tbl_hi,
   input  logic        sof,
   input  logic        byte_vld,
   input  logic [7:0]  byte_dat,
   input  logic        eof,
   output logic        dec_vld,
   output logic        dec_accept
);
   localparam int unsigned CNT_W  = $clog2(MIN_FRAME + 1);
   localparam int unsigned N_REF  = 3;
   localparam int unsigned AW     = ADDR_BYTES * 8;

   generate
      if (MIN_FRAME < ADDR_BYTES + 2) begin : g_bad_len
         $error("MIN_FRAME too small to cover the address");
      end
      if (TBL_SIZE != 64) begin : g_bad_tbl
         $error("group table ports assume a 64-entry table");
      end
   endgenerate

   // frame position
   logic [CNT_W-1:0] bcnt_q;
   logic [CNT_W-1:0] idx;
   logic             in_addr;
   logic             first;
   logic             done_q;
   logic             done_eff;

   assign idx      = sof ? '0 : bcnt_q;
   assign in_addr  = byte_vld && (idx < CNT_W'(ADDR_BYTES));
   assign first    = (idx == '0);
   assign done_eff = (byte_vld && sof) ? 1'b0 : done_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         bcnt_q <= CNT_W'(MIN_FRAME);
      end else if (byte_vld) begin
         bcnt_q <= (idx == CNT_W'(MIN_FRAME)) ? idx : idx + 1'b1;
      end
   end

   // comparators: station 0, station 1, broadcast
   logic [N_REF-1:0][AW-1:0] refs;
   logic [N_REF-1:0]         eqs;

   assign refs[0] = {uc0_hi, uc0_lo};
   assign refs[1] = {uc1_hi, uc1_lo};
   assign refs[2] = '1;

   genvar gi;
   generate
      for (gi = 0; gi < N_REF; gi++) begin : g_cmp
         dafilt_exact #(.BYTES(ADDR_BYTES)) u_cmp (
            .clk      (clk),
            .rst_n    (rst_n),
            .upd      (in_addr),
            .first    (first),
            .idx      (idx[BIDX_W-1:0]),
            .dat      (byte_dat),
            .ref_addr (refs[gi]),
            .eq       (eqs[gi])
         );
      end
   endgenerate

   // hash and group table lookup
   logic [HASH_W-1:0]   hash;
   logic                grp;
   logic [TBL_SIZE-1:0] tbl;
   logic                hash_hit;

   dafilt_hash u_hash (
      .clk   (clk),
      .rst_n (rst_n),
      .upd   (in_addr),
      .first (first),
      .idx   (idx[BIDX_W-1:0]),
      .dat   (byte_dat),
      .hash  (hash),
      .grp   (grp)
   );

   assign tbl      = {grp_tbl_hi, grp_tbl_lo};
   assign hash_hit = tbl[hash] & (grp | rx_ctl[2]);

   logic match_c;
   logic match;

   assign match_c = (rx_ctl[0] & eqs[0]) | (rx_ctl[1] & eqs[1]) |
                    (rx_ctl[3] & eqs[2]) | hash_hit;

   generate
      if (MATCH_PIPE) begin : g_pipe
         logic match_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) match_q <= 1'b0;
            else        match_q <= match_c;
         end
         assign match = match_q;
      end else begin : g_comb
         assign match = match_c;
      end
   endgenerate

   // verdict
   logic fire_len;
   logic fire_eof;

   assign fire_len = byte_vld && (idx == CNT_W'(MIN_FRAME - 1)) && !done_eff;
   assign fire_eof = eof && !done_eff && !fire_len;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         done_q     <= 1'b1;
         dec_vld    <= 1'b0;
         dec_accept <= 1'b0;
      end else begin
         done_q     <= done_eff | fire_len | fire_eof;
         dec_vld    <= fire_len | fire_eof;
         dec_accept <= fire_len & match;
      end
   end

   AST_ACC_QUAL: assert property (@(posedge clk) disable iff (!rst_n)
      dec_accept |-> dec_vld); // R10
   AST_LEN_DECIDE: assert property (@(posedge clk) disable iff (!rst_n)
      (byte_vld && !sof && bcnt_q == CNT_W'(MIN_FRAME - 1) && !done_q) |=> dec_vld); // R7
   AST_SHORT_REJECT: assert property (@(posedge clk) disable iff (!rst_n)
      (byte_vld && sof && eof) |=> (dec_vld && !dec_accept)); // R8
   AST_CAUSED: assert property (@(posedge clk) disable iff (!rst_n)
      dec_vld |-> $past(byte_vld || eof)); // R9
endmodule

// File: tb/dafilt_top_test.sv
module dafilt_top_test;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [3:0]  rx_ctl = '0;
   logic [31:0] uc0_lo = '0, uc1_lo = '0, grp_tbl_lo = '0, grp_tbl_hi = '0;
   logic [15:0] uc0_hi = '0, uc1_hi = '0;
   logic        sof = 1'b0, byte_vld = 1'b0, eof = 1'b0;
   logic [7:0]  byte_dat = '0;
   logic        dec_vld, dec_accept;

   int checks = 0, errors = 0;
   int cyc = 0;
   int n_dec = 0;
   int last_cyc = -1;
   logic last_acc = 1'b0;
   int exp_cyc = 0;
   bit finished = 0;
   logic [31:0] rng = 32'h1234_5679;

   always #5 clk = ~clk;
   always @(posedge clk) cyc <= cyc + 1;

   dafilt_top uut (
      .clk(clk), .rst_n(rst_n), .rx_ctl(rx_ctl),
      .uc0_lo(uc0_lo), .uc0_hi(uc0_hi), .uc1_lo(uc1_lo), .uc1_hi(uc1_hi),
      .grp_tbl_lo(grp_tbl_lo), .grp_tbl_hi(grp_tbl_hi),
      .sof(sof), .byte_vld(byte_vld), .byte_dat(byte_dat), .eof(eof),
      .dec_vld(dec_vld), .dec_accept(dec_accept)
   );

   always @(negedge clk) begin
      if (dec_vld) begin
         n_dec    = n_dec + 1;
         last_acc = dec_accept;
         last_cyc = cyc;
      end
      if (rst_n && dec_accept && !dec_vld) begin
         errors = errors + 1;
         $display("FAIL R10: dec_accept=1 expected 0 while dec_vld=0");
      end
   end

   function automatic logic [31:0] nxt(input logic [31:0] s);
      logic [31:0] x;
      x = s ^ (s << 13);
      x = x ^ (x >> 17);
      return x ^ (x << 5);
   endfunction

   function automatic bit model(input logic [47:0] a, input logic [3:0] c,
                                input logic [47:0] u0, input logic [47:0] u1,
                                input logic [63:0] t);
      int h = 0;
      for (int k = 0; k < 8; k++)
         for (int j = 0; j < 6; j++)
            h = h ^ (int'(a[6*k+j]) << j);
      return (c[0] && a == u0) || (c[1] && a == u1) || (c[3] && a == '1) ||
             ((c[2] || a[0]) && t[h]);
   endfunction

   task automatic chk(input string tag, input int got, input int exp);
      checks = checks + 1;
      if (got != exp) begin
         errors = errors + 1;
         $display("FAIL %s: got %0d expected %0d", tag, got, exp);
      end
   endtask

   // send len bytes; address in the first six; eof with last byte if eof_last
   task automatic send(input logic [47:0] a, input int len, input bit eof_last);
      for (int i = 0; i < len; i++) begin
         @(negedge clk);
         byte_vld = 1'b1;
         sof      = (i == 0);
         byte_dat = (i < 6) ? a[8*i +: 8] : 8'(8'h5a + i);
         eof      = eof_last && (i == len - 1);
         if (i == 11 || (eof_last && i == len - 1 && len < 12)) exp_cyc = cyc + 1;
      end
      @(negedge clk);
      byte_vld = 1'b0; sof = 1'b0; eof = 1'b0;
   endtask

   task automatic frame(input string tag, input logic [47:0] a, input int len,
                        input bit eof_last, input int exp_acc);
      n_dec = 0;
      send(a, len, eof_last);
      repeat (3) @(negedge clk);
      chk({tag, " count"}, n_dec, 1);
      chk({tag, " accept"}, int'(last_acc), exp_acc);
      chk({tag, " timing"}, last_cyc, exp_cyc);
   endtask

   task automatic setup(input logic [3:0] c, input logic [47:0] u0, input logic [47:0] u1,
                        input logic [63:0] t);
      rx_ctl = c;
      {uc0_hi, uc0_lo} = u0;
      {uc1_hi, uc1_lo} = u1;
      {grp_tbl_hi, grp_tbl_lo} = t;
   endtask

   initial begin
      #2000000;
      if (!finished) begin
         errors = errors + 1;
         $display("FAIL watchdog: run did not complete");
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end

   initial begin
      logic [47:0] s0, s1, ad;
      logic [63:0] tb;
      repeat (3) @(negedge clk);
      chk("R10 reset vld", int'(dec_vld), 0);
      chk("R10 reset acc", int'(dec_accept), 0);
      rst_n = 1'b1;
      @(negedge clk);

      s0 = 48'h0a0b0c0d0e02;
      s1 = 48'h665544332210;
      // R1 / R2: station matches, byte order per R2
      setup(4'b0001, s0, s1, '0);
      frame("R1 uc0 hit", s0, 12, 0, 1);
      setup(4'b0000, s0, s1, '0);
      frame("R1 uc0 disabled", s0, 12, 0, 0);
      setup(4'b0010, s0, s1, '0);
      frame("R2 uc1 hit", s1, 12, 0, 1);
      frame("R2 uc1 byte5 differs", s1 ^ 48'h010000000000, 12, 0, 0);
      frame("R2 uc1 byte0 differs", s1 ^ 48'h000000000004, 12, 0, 0);
      // R3 broadcast
      setup(4'b1000, s0, s1, '0);
      frame("R3 bcast hit", '1, 12, 0, 1);
      setup(4'b0000, s0, s1, '0);
      frame("R3 bcast disabled", '1, 12, 0, 0);
      // R8: short frames rejected even when matching
      setup(4'b1000, s0, s1, '1);
      frame("R8 short 6", '1, 6, 1, 0);
      frame("R8 single byte", '1, 1, 1, 0);
      frame("R8 eof with 12th byte", '1, 12, 1, 1);
      // R7 / R9: long frame gives one verdict, eof afterwards ignored
      frame("R7 long 20", '1, 20, 1, 1);
      // R9: restart with sof
      n_dec = 0;
      send(s0, 4, 0);
      setup(4'b0001, s0, s1, '0);
      frame("R9 restart", s0, 12, 0, 1);

      // R4 / R5 sweep of every hash value
      for (int h = 0; h < 64; h++) begin
         ad = {40'h0, 8'(h)};
         setup(4'b0100, '0, '0, 64'(1) << h);
         frame("R4 hash hit", ad, 12, 0, 1);
         setup(4'b0100, '0, '0, 64'(1) << (h ^ 1));
         frame("R4 hash miss", ad, 12, 0, 0);
         setup(4'b0000, '0, '0, '1);
         frame("R5 group only", ad, 12, 0, h & 1);
      end

      // R6 random frames against model
      for (int n = 0; n < 80; n++) begin
         rng = nxt(rng); s0 = {rng[15:0], nxt(rng)};
         rng = nxt(nxt(rng)); s1 = {rng[31:16], nxt(rng)};
         rng = nxt(nxt(rng)); tb = {rng, nxt(rng)} & {nxt(nxt(rng)), nxt(rng)};
         rng = nxt(nxt(nxt(rng)));
         case (rng[2:0])
            3'd0: ad = s0;
            3'd1: ad = s1;
            3'd2: ad = '1;
            default: ad = {rng[31:16], nxt(rng)};
         endcase
         setup(rng[7:4], s0, s1, tb);
         frame("R6 random", ad, 12 + int'(rng[9:8]), rng[10],
               int'(model(ad, rng[7:4], s0, s1, tb)));
      end

      finished = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end
endmodule